// File: doc/BRIEF.md
# ADC Conversion Start and Repeat Controller

This block is the digital sequencer in front of an on-chip analog-to-digital converter working in single-channel repeat mode. Software writes a control word holding an operating mode, the channel to convert, a start-source select and a run bit. Once the run flag is set, the controller issues a one-cycle start strobe with the channel number to the converter. It waits for the converter's done pulse, latches the result, raises a one-cycle interrupt request and then launches the next conversion on the same channel. This repeats until software writes the run bit to zero.

The run flag has three possible sources, chosen by the start-source field: a software write, a falling edge on an active-low trigger pin, or an underflow pulse from a timer. The trigger pin first passes through a synchronizer chain and then a falling-edge detector. The hardware can set the flag but never clears it. A conversion that is in flight when software clears the flag still completes and still raises its interrupt.

The sequencer has three states. `SQ_IDLE` waits for the run flag with the repeat mode selected and goes to `SQ_LAUNCH` (transition *go*). `SQ_LAUNCH` drives the start strobe for one cycle and always goes to `SQ_WAIT` (transition *issued*). `SQ_WAIT` holds until the done pulse arrives. On done it returns to `SQ_LAUNCH` if the flag is still set and the mode is still repeat (transition *again*); otherwise it goes to `SQ_IDLE` (transition *halt*).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, run_flag, conv_start and irq are 0, and conv_chan and result are all zeros.
- R2: A write with reg_run=1 and reg_trig=00 (software start) sets run_flag from the following cycle. With reg_mode=01 (single-channel repeat), conv_start is high for one cycle, one cycle after run_flag rises, and conv_chan equals the written channel.
- R3: With reg_trig=01 (pin start), run_flag is set when ext_trig_n falls. After the pin falls ahead of a clock edge, the flag reads 1 following the SYNC_STAGES+1-th edge. A rising edge, a steady low level, and a software write of reg_run=1 each leave the flag unchanged.
- R4: With reg_trig=10 (timer start), a tmr_uflow pulse sets run_flag at the next clock edge.
- R5: While run_flag=1 and the mode is 01, every conv_done is followed in the next cycle by another one-cycle conv_start. conv_chan takes the channel field at each launch and holds it until the next launch.
- R6: irq is high for exactly the cycles in which conv_done is high while a conversion is outstanding. A conv_done with no conversion outstanding raises no irq.
- R7: result takes conv_data at the clock edge that ends an irq cycle and holds it until the next irq.
- R8: run_flag is cleared only by a write with reg_run=0. Hardware never clears it.
- R9: When run_flag is cleared during a conversion, that conversion still ends with irq, and no further conv_start is issued.
- R10: Trigger events and software starts that arrive while run_flag=1 produce no extra conv_start.
- R11: With reg_mode other than 01, a set run_flag launches no conversion.
- R12: With reg_trig=11, neither the pin, the timer nor a software write of reg_run=1 sets run_flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_mode | input | 2 | Operating mode (01 = single-channel repeat) |
| reg_chan | input | CH_W | Channel to convert |
| reg_trig | input | 2 | Start source: 00 software, 01 pin, 10 timer, 11 none |
| reg_run | input | 1 | Run bit value written |
| ext_trig_n | input | 1 | Asynchronous active-low trigger pin |
| tmr_uflow | input | 1 | One-cycle timer underflow pulse |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | RES_W | Converter result word |
| run_flag | output | 1 | Start/execution flag read-back |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | CH_W | Channel driven to the converter |
| irq | output | 1 | One-cycle conversion-complete interrupt request |
| result | output | RES_W | Last latched conversion result |

## Verification
The bench builds the block with a three-stage synchronizer, a three-bit channel field and a twelve-bit result. The longer chain moves the pin-to-flag delay away from the default, so a design that hardcodes two stages shows up as a one-cycle mismatch. The wider channel field carries channel codes above three, which exposes any truncation at the launch latch. The converter stub answers three cycles after each strobe. That latency makes it possible to write the run bit to zero while a conversion is outstanding, and to inject a stray done pulse while the sequencer is idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        TRG_SW   = 2'b00,
        TRG_PIN  = 2'b01,
        TRG_TMR  = 2'b10,
        TRG_NONE = 2'b11
    } trig_sel_e;

    typedef enum logic [1:0] {
        MD_ONCE      = 2'b00,
        MD_CONT      = 2'b01,
        MD_SWEEP     = 2'b10,
        MD_SWEEP_REP = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'b00,
        SQ_LAUNCH = 2'b01,
        SQ_WAIT   = 2'b10
    } seq_state_e;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_pulse
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b1;
                    else        sync_q[i] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b1;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[TOP];
    end

    always_comb fall_pulse = last_q & ~sync_q[TOP];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse); // R3

endmodule

// File: rtl/adc_run_flag.sv
module adc_run_flag
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_run,
    input  trig_sel_e wr_trig,
    input  trig_sel_e cur_trig,
    input  logic      pin_fall,
    input  logic      tmr_uflow,
    output logic      run_q
);
    logic run_d;

    always_comb begin
        run_d = run_q;
        if (wr_en) begin
            if (!wr_run)               run_d = 1'b0;
            else if (wr_trig == TRG_SW) run_d = 1'b1;
        end else begin
            unique case (cur_trig)
                TRG_PIN:  run_d = run_q | pin_fall;
                TRG_TMR:  run_d = run_q | tmr_uflow;
                default:  run_d = run_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    AST_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(wr_en && !wr_run)); // R8

    AST_SET_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> $past(wr_en || pin_fall || tmr_uflow)); // R3

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 2,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_flag,
    input  op_mode_e         mode,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             irq,
    output logic [RES_W-1:0] result
);
    seq_state_e state_q, state_d;
    logic       go;
    logic       entering_launch;

    always_comb go = run_flag && (mode == MD_CONT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (go) state_d = SQ_LAUNCH;
            SQ_LAUNCH: state_d = SQ_WAIT;
            SQ_WAIT:   if (conv_done) state_d = go ? SQ_LAUNCH : SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        conv_start = 1'b0;
        irq        = 1'b0;
        unique case (state_q)
            SQ_LAUNCH: conv_start = 1'b1;
            SQ_WAIT:   irq        = conv_done;
            default:   ;
        endcase
    end

    always_comb entering_launch = (state_d == SQ_LAUNCH) && (state_q != SQ_LAUNCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_chan <= '0;
            result    <= '0;
        end else begin
            if (entering_launch) conv_chan <= chan_sel;
            if (irq)             result    <= conv_data;
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R5

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(conv_chan)); // R5

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> conv_done); // R6

    AST_LAUNCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(run_flag)); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> $stable(result)); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W        = 2,
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_mode,
    input  logic [CH_W-1:0]  reg_chan,
    input  logic [1:0]       reg_trig,
    input  logic             reg_run,
    input  logic             ext_trig_n,
    input  logic             tmr_uflow,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             run_flag,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             irq,
    output logic [RES_W-1:0] result
);
    op_mode_e        mode_q;
    trig_sel_e       trig_q;
    logic [CH_W-1:0] chan_q;
    logic            pin_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_ONCE;
            trig_q <= TRG_SW;
            chan_q <= '0;
        end else if (reg_wr) begin
            mode_q <= op_mode_e'(reg_mode);
            trig_q <= trig_sel_e'(reg_trig);
            chan_q <= reg_chan;
        end
    end

    adc_trig_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (ext_trig_n),
        .fall_pulse (pin_fall)
    );

    adc_run_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_run    (reg_run),
        .wr_trig   (trig_sel_e'(reg_trig)),
        .cur_trig  (trig_q),
        .pin_fall  (pin_fall),
        .tmr_uflow (tmr_uflow),
        .run_q     (run_flag)
    );

    adc_conv_fsm #(
        .CH_W  (CH_W),
        .RES_W (RES_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_flag   (run_flag),
        .mode       (mode_q),
        .chan_sel   (chan_q),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .irq        (irq),
        .result     (result)
    );

    AST_STOPPED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_flag && !conv_start) |=> !conv_start); // R9

    AST_RUN_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MD_CONT && !conv_start) |=> !conv_start); // R11

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    localparam int CHW  = 3;
    localparam int RESW = 12;
    localparam int SYNC = 3;
    localparam int LAT  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_mode = '0;
    logic [CHW-1:0]  reg_chan = '0;
    logic [1:0]      reg_trig = '0;
    logic            reg_run = 1'b0;
    logic            ext_trig_n = 1'b1;
    logic            tmr_uflow = 1'b0;
    logic            conv_done = 1'b0;
    logic [RESW-1:0] conv_data = '0;
    logic            run_flag, conv_start, irq;
    logic [CHW-1:0]  conv_chan;
    logic [RESW-1:0] result;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.CH_W(CHW), .RES_W(RESW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_mode(reg_mode),
        .reg_chan(reg_chan), .reg_trig(reg_trig), .reg_run(reg_run),
        .ext_trig_n(ext_trig_n), .tmr_uflow(tmr_uflow), .conv_done(conv_done),
        .conv_data(conv_data), .run_flag(run_flag), .conv_start(conv_start),
        .conv_chan(conv_chan), .irq(irq), .result(result)
    );

    int    n_total = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    ended   = 0;
    string cur_req = "R1";
    int    n_start = 0;
    int    n_irq   = 0;
    bit    inject_done = 0;

    task automatic chk(string req, int act, int exp, string what);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        ended = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Behavioural reference model
    int m_run, m_mode, m_chan, m_trig, m_phase, m_lchan, m_result;
    int hist[$];

    task automatic model_reset();
        m_run = 0; m_mode = 0; m_chan = 0; m_trig = 0;
        m_phase = 0; m_lchan = 0; m_result = 0;
        hist.delete();
        for (int i = 0; i <= SYNC; i++) hist.push_back(1);
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit fall;
            bit go;
            fall = (hist[SYNC] == 1) && (hist[SYNC-1] == 0);
            hist.push_front(int'(ext_trig_n));
            void'(hist.pop_back());
            go = (m_run == 1) && (m_mode == 1);
            case (m_phase)
                0: if (go) begin m_phase = 1; m_lchan = m_chan; end
                1: m_phase = 2;
                default: if (conv_done) begin
                    m_result = int'(conv_data);
                    if (go) begin m_phase = 1; m_lchan = m_chan; end
                    else m_phase = 0;
                end
            endcase
            if (reg_wr) begin
                if (!reg_run) m_run = 0;
                else if (reg_trig == 2'b00) m_run = 1;
                m_mode = int'(reg_mode);
                m_chan = int'(reg_chan);
                m_trig = int'(reg_trig);
            end else if (m_trig == 1 && fall) m_run = 1;
            else if (m_trig == 2 && tmr_uflow) m_run = 1;
        end
    end

    // Converter stub with fixed latency
    int stub_cnt = 0;
    int data_seq = 17;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
                conv_done = 1'b1;
                conv_data = data_seq[RESW-1:0];
                data_seq  = (data_seq * 5 + 301) % 4096;
            end
        end
        if (inject_done) begin
            conv_done = 1'b1;
            conv_data = 12'habc;
        end
        if (rst_n && conv_start) stub_cnt = LAT;
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !ended) begin
            int exp_irq;
            exp_irq = (m_phase == 2 && conv_done) ? 1 : 0;
            n_total++;
            if (int'(run_flag) != m_run || int'(conv_start) != (m_phase == 1 ? 1 : 0) ||
                int'(irq) != exp_irq || int'(conv_chan) != m_lchan ||
                int'(result) != m_result) begin
                n_fail++;
                $display("FAIL %s cycle %0d: actual run=%0d start=%0d irq=%0d chan=%0d res=%0d expected run=%0d start=%0d irq=%0d chan=%0d res=%0d",
                         cur_req, cyc, run_flag, conv_start, irq, conv_chan, result,
                         m_run, (m_phase == 1), exp_irq, m_lchan, m_result);
            end
            if (conv_start) n_start++;
            if (irq) n_irq++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    task automatic wr(int mode, int chan, int trig, int run);
        @(negedge clk);
        reg_wr = 1'b1; reg_mode = mode[1:0]; reg_chan = chan[CHW-1:0];
        reg_trig = trig[1:0]; reg_run = run[0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tmr_pulse();
        @(negedge clk); tmr_uflow = 1'b1;
        @(negedge clk); tmr_uflow = 1'b0;
    endtask

    initial begin
        int s0;
        int i0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk); #3;
        cur_req = "R1";
        chk("R1", run_flag, 0, "run_flag");
        chk("R1", conv_start, 0, "conv_start");
        chk("R1", irq, 0, "irq");
        chk("R1", conv_chan, 0, "conv_chan");
        chk("R1", result, 0, "result");

        cur_req = "R11";
        s0 = n_start;
        wr(0, 5, 0, 1);
        idle(12);
        chk("R11", run_flag, 1, "flag set in once mode");
        chk("R11", n_start - s0, 0, "starts in non-repeat mode");
        wr(2, 5, 0, 1);
        idle(8);
        chk("R11", n_start - s0, 0, "starts in sweep mode");
        wr(1, 5, 0, 0);

        cur_req = "R2";
        s0 = n_start; i0 = n_irq;
        wr(1, 6, 0, 1);
        #3;
        chk("R2", run_flag, 1, "flag after software start");
        idle(40);
        cur_req = "R5";
        chk("R5", (n_start - s0) >= 6 ? 1 : 0, 1, "repeated launches");
        chk("R6", n_irq - i0, n_start - s0 - ((m_phase != 0) ? 1 : 0), "irq per finished conversion");
        wr(1, 3, 0, 1);
        idle(20);
        chk("R5", conv_chan, 3, "new channel after change");
        chk("R8", run_flag, 1, "flag still set while repeating");

        cur_req = "R10";
        wr(1, 3, 2, 1);
        tmr_pulse();
        idle(2);
        tmr_pulse();
        idle(10);
        chk("R10", run_flag, 1, "flag unaffected by extra trigger");

        cur_req = "R9";
        idle(1);
        wr(1, 3, 2, 0);
        idle(10);
        chk("R9", run_flag, 0, "flag cleared by write");
        s0 = n_start;
        idle(15);
        chk("R9", n_start - s0, 0, "no launch after clear");

        cur_req = "R6";
        i0 = n_irq;
        @(negedge clk); inject_done = 1'b1;
        @(negedge clk); inject_done = 1'b0;
        idle(2);
        chk("R6", n_irq - i0, 0, "irq from stray done");

        cur_req = "R4";
        s0 = n_start;
        tmr_pulse();
        #3;
        chk("R4", run_flag, 1, "flag after timer underflow");
        idle(20);
        chk("R4", (n_start - s0) > 0 ? 1 : 0, 1, "launches after timer start");
        wr(1, 7, 1, 0);
        idle(10);

        cur_req = "R3";
        wr(1, 7, 1, 1);
        idle(3);
        chk("R3", run_flag, 0, "software write under pin select");
        @(negedge clk); ext_trig_n = 1'b0;
        idle(SYNC + 2);
        chk("R3", run_flag, 1, "flag after pin fall");
        idle(20);
        @(negedge clk); ext_trig_n = 1'b1;
        idle(10);
        wr(1, 7, 1, 0);
        idle(8);
        @(negedge clk); ext_trig_n = 1'b0;
        @(negedge clk); ext_trig_n = 1'b1;
        idle(SYNC + 4);
        chk("R3", run_flag, 1, "flag after short pin pulse");
        wr(1, 7, 1, 0);
        idle(8);

        cur_req = "R12";
        wr(1, 2, 3, 1);
        tmr_pulse();
        @(negedge clk); ext_trig_n = 1'b0;
        idle(SYNC + 3);
        @(negedge clk); ext_trig_n = 1'b1;
        idle(SYNC + 3);
        chk("R12", run_flag, 0, "no source sets flag with select 11");

        cur_req = "R7";
        wr(1, 4, 0, 1);
        idle(30);
        wr(1, 4, 0, 0);
        idle(10);
        chk("R7", run_flag, 0, "final stop");

        finish_up();
    end

endmodule